// File: doc/BRIEF.md
# Extended accumulator ALU unit

This unit carries out the prefixed single-byte accumulator operations of an 8-bit processor core: two's-complement negate, a non-destructive AND test, nibble rotates right and left between the accumulator and a memory byte, and an unsigned multiply of the two bytes of a 16-bit register pair. The sequencer presents the opcode, the accumulator, the flag byte, an operand byte, the memory byte addressed for the rotates and the register pair for the multiply. It then pulses `start` for one cycle.

One clock later the unit returns the new accumulator and flag byte, and raises `done` for one cycle. It also raises a memory write strobe with its data byte for the rotates, a product write strobe with the 16-bit product for the multiply, or an invalid-instruction flag. Several operations exist only when the extended-mode enable is high. With that enable high, the opcode range below 0x40 is decoded as a compact group of port and test operations. Port transfers themselves happen outside the unit.

Top module: `xalu_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the unit clears `done`, `mem_we`, `prod_we` and `illegal`, and sets `acc_out`, `flags_out`, `mem_wdata` and `product` to zero.
- R2: Each cycle in which `start` is high produces one result, and `done` is high in exactly the following cycle. `mem_we` and `prod_we` are high only in a cycle where `done` is high.
- R3: The flag byte holds sign in bit 7, zero in bit 6, half-carry in bit 4, parity/overflow in bit 2, subtract in bit 1 and carry in bit 0. Bits 5 and 3 of `flags_out` always equal bits 5 and 3 of `flags_in`.
- R4: Opcode 0x44 (negate, legal in either mode) returns 0 minus A and sets subtract. Carry is set when the old A was nonzero, overflow exactly when the old A was 0x80, and half-carry when the low nibble of the old A was nonzero. Sign and zero come from the result.
- R5: The AND test (opcode 0x64 in extended mode, operand taken as an immediate) leaves A unchanged. It sets half-carry and clears subtract and carry. Sign is bit 7 of A AND operand, zero is set when that value is zero, and parity is set when it has an even number of ones.
- R6: Opcode 0x67 writes memory with the old memory high nibble in bits 3:0 and the old A low nibble in bits 7:4. The new A keeps its high nibble and takes the old memory low nibble.
- R7: Opcode 0x6F writes memory with the old memory low nibble in bits 7:4 and the old A low nibble in bits 3:0. The new A keeps its high nibble and takes the old memory high nibble.
- R8: Both nibble rotates keep carry, clear half-carry and subtract, and take sign, zero and even parity from the new A.
- R9: Opcodes 0x4C, 0x5C, 0x6C and 0x7C in extended mode raise `prod_we`. `product` then equals the unsigned product of `pair_in[15:8]` and `pair_in[7:0]`, and A and the flags pass through unchanged.
- R10: In extended mode, an opcode below 0x40 is decoded by its bits 2:0. Value 4 is the AND test against `operand`. Values 0 and 1 (port input/output) are legal and leave A, the flags and both strobes untouched. Every other value is invalid. Without extended mode, every opcode below 0x40 is invalid.
- R11: An invalid opcode raises `illegal` with `done`, raises neither strobe, and passes A and the flags through unchanged. Invalid opcodes are 0x64 or a multiply opcode without extended mode, and any opcode not named in R4 to R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One result is requested this cycle |
| ext_en | input | 1 | Extended-mode enable |
| opcode | input | 8 | Byte following the prefix |
| acc_in | input | 8 | Current accumulator |
| flags_in | input | 8 | Current flag byte |
| operand | input | 8 | Register or immediate operand for the AND test |
| mem_rdata | input | 8 | Memory byte for the nibble rotates |
| pair_in | input | 16 | Register pair for the multiply |
| done | output | 1 | Result valid |
| acc_out | output | 8 | New accumulator |
| flags_out | output | 8 | New flag byte |
| mem_wdata | output | 8 | Byte to write back to memory |
| mem_we | output | 1 | Memory write strobe |
| product | output | 16 | Multiply result for the register pair |
| prod_we | output | 1 | Register pair write strobe |
| illegal | output | 1 | Invalid instruction |

## Verification
The bench negates 0x00, 0x80, 0x01 and 0x10. A unit that derived carry or half-carry from the result, or overflow from the sign, would flag these wrongly. It runs the AND test on results that are zero with even parity and nonzero with odd parity, to catch an inverted parity sense or a test that overwrites A. The rotates use distinct nibbles and a set carry bit, so that a swapped nibble or a lost carry shows. The bench also tries extended-only and sub-0x40 opcodes with the enable low and high, where a decoder error would show up as a wrong `illegal` or a stray strobe.

// File: rtl/xalu_pkg.sv
// Shared definitions for the extended accumulator ALU: flag bit
// positions (fixed, the flag byte is decoded by neighbours) and the
// internal operation code.
package xalu_pkg;
    localparam int FL_S = 7;
    localparam int FL_Z = 6;
    localparam int FL_H = 4;
    localparam int FL_P = 2;
    localparam int FL_N = 1;
    localparam int FL_C = 0;

    typedef enum logic [2:0] {
        OPX_NEG  = 3'd0,
        OPX_TST  = 3'd1,
        OPX_ROTR = 3'd2,
        OPX_ROTL = 3'd3,
        OPX_MUL  = 3'd4,
        OPX_PORT = 3'd5,
        OPX_BAD  = 3'd6
    } opx_e;
endpackage

// File: rtl/xalu_decode.sv
// Opcode decoder: maps the prefixed opcode and the extended-mode enable
// onto an internal operation. Purely combinational.
// Assumes opcode is the byte that follows the prefix.
module xalu_decode
    import xalu_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic       ext_en,
    output opx_e       op
);
    // Select the operation; everything unlisted is invalid.
    always_comb begin
        op = OPX_BAD;
        if (opcode < 8'h40) begin
            if (ext_en) begin
                case (opcode[2:0])
                    3'd0, 3'd1: op = OPX_PORT;
                    3'd4:       op = OPX_TST;
                    default:    op = OPX_BAD;
                endcase
            end
        end else begin
            case (opcode)
                8'h44:                      op = OPX_NEG;
                8'h64:                      op = ext_en ? OPX_TST : OPX_BAD;
                8'h67:                      op = OPX_ROTR;
                8'h6F:                      op = OPX_ROTL;
                8'h4C, 8'h5C, 8'h6C, 8'h7C: op = ext_en ? OPX_MUL : OPX_BAD;
                default:                    op = OPX_BAD;
            endcase
        end
    end
endmodule

// File: rtl/xalu_core.sv
// Datapath: computes the new accumulator, memory byte and product for
// the decoded operation. Combinational; flags are formed elsewhere.
// Assumes W is even (nibble = W/2).
module xalu_core
    import xalu_pkg::*;
#(
    parameter int W = 8
) (
    input  opx_e           op,
    input  logic [W-1:0]   acc_in,
    input  logic [W-1:0]   operand,
    input  logic [W-1:0]   mem_rdata,
    input  logic [2*W-1:0] pair_in,
    output logic [W-1:0]   acc_nxt,
    output logic [W-1:0]   tst_val,
    output logic [W-1:0]   mem_nxt,
    output logic           mem_wr,
    output logic [2*W-1:0] prod_nxt,
    output logic           prod_wr
);
    localparam int NB = W / 2;

    logic [W-1:0] neg_val;

    assign neg_val  = '0 - acc_in;
    assign tst_val  = acc_in & operand;
    assign prod_nxt = pair_in[2*W-1:W] * pair_in[W-1:0];

    // Choose the accumulator and memory byte for each operation.
    always_comb begin
        acc_nxt = acc_in;
        mem_nxt = '0;
        mem_wr  = 1'b0;
        prod_wr = 1'b0;
        case (op)
            OPX_NEG: acc_nxt = neg_val;
            OPX_ROTR: begin
                mem_nxt = {acc_in[NB-1:0], mem_rdata[W-1:NB]};
                acc_nxt = {acc_in[W-1:NB], mem_rdata[NB-1:0]};
                mem_wr  = 1'b1;
            end
            OPX_ROTL: begin
                mem_nxt = {mem_rdata[NB-1:0], acc_in[NB-1:0]};
                acc_nxt = {acc_in[W-1:NB], mem_rdata[W-1:NB]};
                mem_wr  = 1'b1;
            end
            OPX_MUL: prod_wr = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/xalu_flags.sv
// Flag former: builds the new flag byte from the operation, the old
// accumulator, the datapath results and the old flags.
// Assumes the bit layout of xalu_pkg; bits 5 and 3 always pass through.
module xalu_flags
    import xalu_pkg::*;
#(
    parameter int W = 8
) (
    input  opx_e         op,
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] acc_nxt,
    input  logic [W-1:0] tst_val,
    input  logic [7:0]   flags_in,
    output logic [7:0]   flags_nxt
);
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    // Per-operation flag rules.
    always_comb begin
        flags_nxt = flags_in;
        case (op)
            OPX_NEG: begin
                flags_nxt[FL_S] = acc_nxt[W-1];
                flags_nxt[FL_Z] = (acc_nxt == '0);
                flags_nxt[FL_H] = |acc_in[3:0];
                flags_nxt[FL_P] = (acc_in == MIN_NEG);
                flags_nxt[FL_N] = 1'b1;
                flags_nxt[FL_C] = |acc_in;
            end
            OPX_TST: begin
                flags_nxt[FL_S] = tst_val[W-1];
                flags_nxt[FL_Z] = (tst_val == '0);
                flags_nxt[FL_H] = 1'b1;
                flags_nxt[FL_P] = ~^tst_val;
                flags_nxt[FL_N] = 1'b0;
                flags_nxt[FL_C] = 1'b0;
            end
            OPX_ROTR, OPX_ROTL: begin
                flags_nxt[FL_S] = acc_nxt[W-1];
                flags_nxt[FL_Z] = (acc_nxt == '0);
                flags_nxt[FL_H] = 1'b0;
                flags_nxt[FL_P] = ~^acc_nxt;
                flags_nxt[FL_N] = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/xalu_top.sv
// Extended accumulator ALU top: decodes, computes and registers one
// result per start pulse; done follows start by one cycle.
// Assumes the sequencer holds no expectation of outputs outside done.
module xalu_top
    import xalu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           ext_en,
    input  logic [7:0]     opcode,
    input  logic [W-1:0]   acc_in,
    input  logic [7:0]     flags_in,
    input  logic [W-1:0]   operand,
    input  logic [W-1:0]   mem_rdata,
    input  logic [2*W-1:0] pair_in,
    output logic           done,
    output logic [W-1:0]   acc_out,
    output logic [7:0]     flags_out,
    output logic [W-1:0]   mem_wdata,
    output logic           mem_we,
    output logic [2*W-1:0] product,
    output logic           prod_we,
    output logic           illegal
);
    opx_e           op;
    logic [W-1:0]   acc_nxt, tst_val, mem_nxt;
    logic           mem_wr, prod_wr;
    logic [2*W-1:0] prod_nxt;
    logic [7:0]     flags_nxt;

    xalu_decode u_dec (
        .opcode (opcode),
        .ext_en (ext_en),
        .op     (op)
    );

    xalu_core #(.W(W)) u_core (
        .op        (op),
        .acc_in    (acc_in),
        .operand   (operand),
        .mem_rdata (mem_rdata),
        .pair_in   (pair_in),
        .acc_nxt   (acc_nxt),
        .tst_val   (tst_val),
        .mem_nxt   (mem_nxt),
        .mem_wr    (mem_wr),
        .prod_nxt  (prod_nxt),
        .prod_wr   (prod_wr)
    );

    xalu_flags #(.W(W)) u_flags (
        .op        (op),
        .acc_in    (acc_in),
        .acc_nxt   (acc_nxt),
        .tst_val   (tst_val),
        .flags_in  (flags_in),
        .flags_nxt (flags_nxt)
    );

    // Result register: capture on start, strobes last one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            acc_out   <= '0;
            flags_out <= '0;
            mem_wdata <= '0;
            mem_we    <= 1'b0;
            product   <= '0;
            prod_we   <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            done    <= start;
            mem_we  <= 1'b0;
            prod_we <= 1'b0;
            illegal <= 1'b0;
            if (start) begin
                acc_out   <= acc_nxt;
                flags_out <= flags_nxt;
                mem_wdata <= mem_nxt;
                mem_we    <= mem_wr;
                product   <= prod_nxt;
                prod_we   <= prod_wr;
                illegal   <= (op == OPX_BAD);
            end
        end
    end
endmodule

// File: rtl/xalu_chk.sv
// Protocol and flag checker for xalu_top, attached by bind.
module xalu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        ext_en,
    input logic [7:0]  opcode,
    input logic [7:0]  acc_in,
    input logic [7:0]  flags_in,
    input logic        done,
    input logic [7:0]  acc_out,
    input logic [7:0]  flags_out,
    input logic        mem_we,
    input logic        prod_we,
    input logic        illegal
);
    // R2
    done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    // R2
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    // R2
    strobe_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || prod_we) |-> done);
    // R11
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_we && !prod_we));
    // R3
    spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (flags_out[5] == $past(flags_in[5]) && flags_out[3] == $past(flags_in[3])));
    // R4
    neg_sub_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && opcode == 8'h44) |=> (flags_out[1] && !illegal));
    // R4
    neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && opcode == 8'h44 && acc_in == 8'h00) |=> (flags_out[6] && !flags_out[0]));
    // R5
    test_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ext_en && opcode == 8'h64) |=> (acc_out == $past(acc_in) && flags_out[4]));
    // R8
    rot_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (opcode == 8'h67 || opcode == 8'h6F)) |=> (flags_out[0] == $past(flags_in[0]) && mem_we));
    // R9
    mul_needs_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !ext_en && opcode == 8'h4C) |=> (illegal && !prod_we));
endmodule

bind xalu_top xalu_chk u_xalu_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ext_en    (ext_en),
    .opcode    (opcode),
    .acc_in    (acc_in),
    .flags_in  (flags_in),
    .done      (done),
    .acc_out   (acc_out),
    .flags_out (flags_out),
    .mem_we    (mem_we),
    .prod_we   (prod_we),
    .illegal   (illegal)
);

// File: tb/tb_xalu_top.sv
module tb_xalu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ext_en = 1'b0;
    logic [7:0]  opcode = '0;
    logic [7:0]  acc_in = '0;
    logic [7:0]  flags_in = '0;
    logic [7:0]  operand = '0;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] pair_in = '0;
    logic        done, mem_we, prod_we, illegal;
    logic [7:0]  acc_out, flags_out, mem_wdata;
    logic [15:0] product;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    xalu_top dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ext_en(ext_en),
        .opcode(opcode), .acc_in(acc_in), .flags_in(flags_in),
        .operand(operand), .mem_rdata(mem_rdata), .pair_in(pair_in),
        .done(done), .acc_out(acc_out), .flags_out(flags_out),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .product(product),
        .prod_we(prod_we), .illegal(illegal)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one operation and sample the result one cycle later.
    task automatic issue(input logic ext, input logic [7:0] op, input logic [7:0] a,
                         input logic [7:0] f, input logic [7:0] opnd,
                         input logic [7:0] m, input logic [15:0] pr);
        @(negedge clk);
        ext_en = ext; opcode = op; acc_in = a; flags_in = f;
        operand = opnd; mem_rdata = m; pair_in = pr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 done", done, 0);
        chk("R1 strobes", {mem_we, prod_we, illegal}, 0);
        chk("R1 acc", acc_out, 0);
        chk("R1 flags", flags_out, 0);
    endtask

    task automatic t_negate();
        issue(0, 8'h44, 8'h01, 8'h28, 0, 0, 0);
        chk("R2 done", done, 1);
        chk("R4 acc 01", acc_out, 8'hFF);
        chk("R3 R4 flags 01", flags_out, 8'hBB);
        issue(0, 8'h44, 8'h00, 8'hFF, 0, 0, 0);
        chk("R4 acc 00", acc_out, 8'h00);
        chk("R3 R4 flags 00", flags_out, 8'h6A);
        issue(1, 8'h44, 8'h80, 8'h00, 0, 0, 0);
        chk("R4 acc 80", acc_out, 8'h80);
        chk("R4 flags 80", flags_out, 8'h87);
        issue(0, 8'h44, 8'h10, 8'h00, 0, 0, 0);
        chk("R4 acc 10", acc_out, 8'hF0);
        chk("R4 flags 10", flags_out, 8'h83);
        @(negedge clk);
        chk("R2 done drops", done, 0);
    endtask

    task automatic t_test();
        issue(1, 8'h64, 8'hF0, 8'hFF, 8'h0F, 0, 0);
        chk("R5 acc kept", acc_out, 8'hF0);
        chk("R5 flags zero", flags_out, 8'h7C);
        chk("R5 legal", illegal, 0);
        issue(1, 8'h3C, 8'hFF, 8'h00, 8'h83, 0, 0);
        chk("R10 R5 acc", acc_out, 8'hFF);
        chk("R10 R5 flags odd", flags_out, 8'h90);
        issue(0, 8'h64, 8'h12, 8'h45, 8'h12, 0, 0);
        chk("R11 test no ext", illegal, 1);
        chk("R11 acc pass", acc_out, 8'h12);
        chk("R11 flags pass", flags_out, 8'h45);
        issue(0, 8'h3C, 8'h12, 8'h00, 8'h12, 0, 0);
        chk("R10 low no ext", illegal, 1);
    endtask

    task automatic t_rotate();
        issue(0, 8'h67, 8'h12, 8'h01, 0, 8'h34, 0);
        chk("R6 mem", mem_wdata, 8'h23);
        chk("R6 we", mem_we, 1);
        chk("R6 acc", acc_out, 8'h14);
        chk("R8 flags right", flags_out, 8'h05);
        issue(0, 8'h6F, 8'h12, 8'hFE, 0, 8'h34, 0);
        chk("R7 mem", mem_wdata, 8'h42);
        chk("R7 acc", acc_out, 8'h13);
        chk("R8 flags left", flags_out, 8'h28);
        @(negedge clk);
        chk("R2 we drops", mem_we, 0);
    endtask

    task automatic t_multiply();
        issue(1, 8'h5C, 8'h77, 8'h11, 0, 0, 16'hFFFF);
        chk("R9 product max", product, 16'hFE01);
        chk("R9 we", prod_we, 1);
        chk("R9 acc pass", acc_out, 8'h77);
        chk("R9 flags pass", flags_out, 8'h11);
        issue(1, 8'h7C, 8'h00, 8'h00, 0, 0, 16'h0C0A);
        chk("R9 product small", product, 16'h0078);
        issue(0, 8'h6C, 8'h00, 8'h00, 0, 0, 16'h0C0A);
        chk("R11 mul no ext", {illegal, prod_we}, 2'b10);
    endtask

    task automatic t_ports_invalid();
        issue(1, 8'h01, 8'h55, 8'h11, 8'hAA, 8'h99, 0);
        chk("R10 port legal", illegal, 0);
        chk("R10 port acc", acc_out, 8'h55);
        chk("R10 port flags", flags_out, 8'h11);
        chk("R10 port strobes", {mem_we, prod_we}, 0);
        issue(1, 8'h02, 8'h55, 8'h11, 0, 0, 0);
        chk("R10 low bad", illegal, 1);
        issue(1, 8'hA0, 8'h66, 8'h22, 0, 8'h10, 16'h0101);
        chk("R11 unknown", illegal, 1);
        chk("R11 unknown acc", acc_out, 8'h66);
        chk("R11 unknown strobes", {mem_we, prod_we}, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                t_negate();
                t_test();
                t_rotate();
                t_multiply();
                t_ports_invalid();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule